// File: doc/BRIEF.md
# Call and Return Address Sequencer

This block carries out the control-transfer side of subroutine calls, interrupt entry, returns and returns from interrupt for a processor core whose program counter is either 16 bits wide or a flat 24 bits wide. A run-time mode input selects the width. The core presents an operation code, the return address (the PC after the instruction), the target fields decoded from the instruction and an interrupt vector. The sequencer then issues one byte-wide push or pop request at a time to an attached stack unit. Each request is held until that unit acknowledges it.

When the byte sequence is finished, the block pulses a PC write strobe with the next PC. Absolute (page-relative) jumps and calls, long calls and interrupt vectors are formed here. A return restores the PC from the popped bytes. A return from interrupt also raises a one-cycle pulse so that outside priority logic can release its active level.

Top module: `callret_seq`

## Requirements
- R1: After reset, and whenever reset is applied in the middle of an operation, busy, push_req, pop_req, pc_we and reti_pulse are 0.
- R2: A call (op 0 long call, op 1 absolute call) pushes pc_in bits [7:0], then bits [15:8], then, only in flat mode (flat=1), bits [23:16].
- R3: A return (op 4, or op 5 for return from interrupt) pops 3 bytes in flat mode or 2 in 16-bit mode. The first popped byte becomes PC[23:16] (flat only), the next becomes PC[15:8] and the last becomes PC[7:0]. In 16-bit mode PC[23:16] is 0.
- R4: A long call targets {tgt_x, tgt_h, tgt_l} in flat mode and {8'h00, tgt_h, tgt_l} in 16-bit mode.
- R5: An absolute call or jump targets (pc_in[15:0] AND 16'hF800) OR T, zero-extended to 24 bits. In flat mode T = {opc_hi, tgt_h, tgt_l}, so opc_hi lands in bits [18:16]. In 16-bit mode T = {opc_hi, tgt_l}, so opc_hi lands in bits [10:8].
- R6: Interrupt entry (op 3) pushes the return address exactly as a call does, and its target is {8'h00, vec}.
- R7: Count clock edges from the edge that accepts start up to and including the edge after which pc_we is high. With the stack always acknowledging, this is 1 for an absolute jump, N+1 for a call, interrupt or 16-bit return, and N+2 for a flat-mode return. N is the number of stack bytes.
- R8: busy is high from the accepting edge through the pc_we cycle and is low in the cycle after. A push or pop request keeps its value, and push_data stays stable, until stk_ack is seen. Push and pop requests are never high together.
- R9: reti_pulse is high for exactly the one pc_we cycle of a return from interrupt, and never for any other operation.
- R10: start is ignored while busy is high. Op codes 6 and 7 are never accepted.
- R11: An absolute jump (op 2) makes no stack request and raises pc_we in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin the operation given by op |
| op | input | 3 | 0 long call, 1 absolute call, 2 absolute jump, 3 interrupt entry, 4 return, 5 return from interrupt |
| flat | input | 1 | 1 selects 24-bit program addresses, 0 selects 16-bit |
| pc_in | input | 24 | Return address, i.e. the PC following the instruction |
| opc_hi | input | 3 | Opcode bits [7:5] used by the absolute forms |
| tgt_x | input | 8 | Target extension byte (flat long call) |
| tgt_h | input | 8 | Target high byte |
| tgt_l | input | 8 | Target low byte |
| vec | input | 16 | Interrupt vector address |
| stk_ack | input | 1 | Stack unit accepts the pending push or pop byte |
| pop_data | input | 8 | Byte delivered by the stack unit for the pending pop |
| push_req | output | 1 | Push request pending |
| pop_req | output | 1 | Pop request pending |
| push_data | output | 8 | Byte to be pushed |
| busy | output | 1 | Operation in progress |
| pc_we | output | 1 | One-cycle strobe: pc_next is the new PC |
| pc_next | output | 24 | Next program counter, valid with pc_we |
| reti_pulse | output | 1 | One-cycle release indication on return from interrupt |

## Verification
The assertions assume that op, flat and the address fields are steady in the cycle start is raised. They also assume that pop_data is valid whenever pop_req and stk_ack are both high. The bench satisfies this with a small stack model that drives pop_data combinationally from its top entry and preloads return addresses before each return. The bench also lets stk_ack alternate every cycle to show that requests and push data are held under backpressure. It raises start during a busy operation and with unused op codes, then confirms at the outputs that neither changed the result.

// File: rtl/callret_pkg.sv
package callret_pkg;
  localparam int BW    = 8;
  localparam int NBYTE = 3;
  localparam int PCW   = NBYTE * BW;
  localparam int OPW   = 3;
  localparam int CW    = $clog2(NBYTE + 1);
  localparam logic [15:0] ABS_KEEP = 16'hF800;

  typedef enum logic [OPW-1:0] {
    OP_LCALL = 3'd0,
    OP_ACALL = 3'd1,
    OP_AJMP  = 3'd2,
    OP_INTR  = 3'd3,
    OP_RET   = 3'd4,
    OP_RETI  = 3'd5
  } op_e;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_SETTLE, S_DONE} seq_st_e;

  function automatic logic op_valid(input logic [OPW-1:0] c);
    return c <= OP_RETI;
  endfunction

  function automatic logic op_pops(input logic [OPW-1:0] c);
    return (c == OP_RET) || (c == OP_RETI);
  endfunction

  // number of stack bytes moved by an operation
  function automatic logic [CW-1:0] byte_count(input logic [OPW-1:0] c, input logic fl);
    if (c == OP_AJMP) return '0;
    return fl ? CW'(NBYTE) : CW'(NBYTE - 1);
  endfunction

  function automatic logic [PCW-1:0] abs_target(input logic [PCW-1:0] pc, input logic [2:0] hi3,
                                                input logic [BW-1:0] h, input logic [BW-1:0] l,
                                                input logic fl);
    logic [PCW-1:0] keep;
    keep = {8'h00, pc[15:0] & ABS_KEEP};
    if (fl) return keep | {5'b0, hi3, h, l};
    return keep | {13'b0, hi3, l};
  endfunction

  function automatic logic [PCW-1:0] long_target(input logic [BW-1:0] x, input logic [BW-1:0] h,
                                                 input logic [BW-1:0] l, input logic fl);
    return fl ? {x, h, l} : {8'h00, h, l};
  endfunction

  function automatic logic [PCW-1:0] intr_target(input logic [15:0] v);
    return {8'h00, v};
  endfunction
endpackage

// File: rtl/callret_target.sv
module callret_target
  import callret_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  logic           flat,
  input  logic [PCW-1:0] pc,
  input  logic [2:0]     opc_hi,
  input  logic [BW-1:0]  tx,
  input  logic [BW-1:0]  th,
  input  logic [BW-1:0]  tl,
  input  logic [15:0]    vec,
  output logic [PCW-1:0] tgt
);
  always_comb begin
    case (op_e'(op))
      OP_LCALL:         tgt = long_target(tx, th, tl, flat);
      OP_ACALL, OP_AJMP: tgt = abs_target(pc, opc_hi, th, tl, flat);
      OP_INTR:          tgt = intr_target(vec);
      default:          tgt = '0;
    endcase
  end
endmodule

// File: rtl/callret_byteseq.sv
module callret_byteseq
  import callret_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] nbytes,
  input  logic          dir_pop,
  input  logic          extra,
  input  logic          ack,
  output logic          push_req,
  output logic          pop_req,
  output logic          take,
  output logic [CW-1:0] idx,
  output logic          done,
  output logic          busy
);
  seq_st_e       st;
  logic [CW-1:0] cnt, nb_q;
  logic          pop_q, ext_q;
  logic          last_byte;

  assign last_byte = (cnt == nb_q - CW'(1));
  assign push_req  = (st == S_XFER) && !pop_q;
  assign pop_req   = (st == S_XFER) && pop_q;
  assign take      = (st == S_XFER) && ack;
  assign idx       = cnt;
  assign done      = (st == S_DONE);
  assign busy      = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      nb_q  <= '0;
      pop_q <= 1'b0;
      ext_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          nb_q  <= nbytes;
          pop_q <= dir_pop;
          ext_q <= extra;
          cnt   <= '0;
          st    <= (nbytes == '0) ? S_DONE : S_XFER;
        end
        S_XFER: if (ack) begin
          if (last_byte) st <= ext_q ? S_SETTLE : S_DONE;
          else           cnt <= cnt + CW'(1);
        end
        S_SETTLE: st <= S_DONE;
        default:  st <= S_IDLE;
      endcase
    end
  end

  // R8
  xfer_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_XFER) |-> (cnt < nb_q));
  // R7
  settle_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SETTLE) |-> (pop_q && ext_q));
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/callret_seq.sv
module callret_seq
  import callret_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [2:0]     op,
  input  logic           flat,
  input  logic [23:0]    pc_in,
  input  logic [2:0]     opc_hi,
  input  logic [7:0]     tgt_x,
  input  logic [7:0]     tgt_h,
  input  logic [7:0]     tgt_l,
  input  logic [15:0]    vec,
  input  logic           stk_ack,
  input  logic [7:0]     pop_data,
  output logic           push_req,
  output logic           pop_req,
  output logic [7:0]     push_data,
  output logic           busy,
  output logic           pc_we,
  output logic [23:0]    pc_next,
  output logic           reti_pulse
);
  logic [OPW-1:0]            op_q;
  logic                      flat_q;
  logic [PCW-1:0]            pc_q, tgt_q, tgt_w;
  logic [NBYTE-1:0][BW-1:0]  ret_b;
  logic                      accept, take, done;
  logic [CW-1:0]             idx, slot;

  assign accept = start && !busy && op_valid(op);

  callret_target u_tgt (
    .op(op), .flat(flat), .pc(pc_in), .opc_hi(opc_hi),
    .tx(tgt_x), .th(tgt_h), .tl(tgt_l), .vec(vec), .tgt(tgt_w)
  );

  callret_byteseq u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept),
    .nbytes(byte_count(op, flat)), .dir_pop(op_pops(op)),
    .extra(op_pops(op) && flat), .ack(stk_ack),
    .push_req(push_req), .pop_req(pop_req), .take(take),
    .idx(idx), .done(done), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= '0;
      flat_q <= 1'b0;
      pc_q   <= '0;
      tgt_q  <= '0;
    end else if (accept) begin
      op_q   <= op;
      flat_q <= flat;
      pc_q   <= pc_in;
      tgt_q  <= tgt_w;
    end
  end

  // push order: low byte first, extension last
  always_comb begin
    push_data = pc_q[BW-1:0];
    for (int k = 1; k < NBYTE; k++)
      if (idx == CW'(k)) push_data = pc_q[k*BW +: BW];
  end

  // pop order: slot 0 = extension, 1 = high, 2 = low
  assign slot = flat_q ? idx : idx + CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ret_b <= '0;
    end else if (take && pop_req) begin
      for (int s = 0; s < NBYTE; s++)
        if (slot == CW'(s)) ret_b[s] <= pop_data;
    end
  end

  assign pc_next    = op_pops(op_q) ? long_target(ret_b[0], ret_b[1], ret_b[2], flat_q) : tgt_q;
  assign pc_we      = done;
  assign reti_pulse = done && (op_q == OP_RETI);

  // R8
  push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !stk_ack) |=> (push_req && $stable(push_data)));
  // R8
  pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !stk_ack) |=> pop_req);
  // R8
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push_req, pop_req}));
  // R8
  we_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |=> (!busy && !pc_we));
  // R9
  reti_with_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reti_pulse |-> pc_we);
  // R10
  hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pc_we) |=> ($stable(pc_q) && $stable(op_q) && $stable(tgt_q)));
  // R11
  jump_no_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_AJMP) |-> (!push_req && !pop_req));
endmodule

// File: tb/tb_callret_seq.sv
module tb_callret_seq;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0]  op;
    logic        flat;
    logic [23:0] pc;
    logic [2:0]  opc;
    logic [7:0]  x, h, l;
    logic [15:0] vec;
    logic [23:0] exp_pc;
    logic [1:0]  nb;
    logic [3:0]  lat;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VT [NV] = '{
    '{3'd0, 1'b1, 24'h123456, 3'd0, 8'hAB, 8'hCD, 8'hEF, 16'h0000, 24'hABCDEF, 2'd3, 4'd4},
    '{3'd0, 1'b0, 24'h001234, 3'd0, 8'hAB, 8'hCD, 8'hEF, 16'h0000, 24'h00CDEF, 2'd2, 4'd3},
    '{3'd1, 1'b1, 24'h12F9AB, 3'd5, 8'h00, 8'h00, 8'h42, 16'h0000, 24'h05F842, 2'd3, 4'd4},
    '{3'd1, 1'b0, 24'h003456, 3'd6, 8'h00, 8'h99, 8'h78, 16'h0000, 24'h003678, 2'd2, 4'd3},
    '{3'd2, 1'b1, 24'h00FFFF, 3'd7, 8'h00, 8'h01, 8'h02, 16'h0000, 24'h07F902, 2'd0, 4'd1},
    '{3'd2, 1'b0, 24'h00A7FF, 3'd1, 8'h00, 8'h00, 8'hCC, 16'h0000, 24'h00A1CC, 2'd0, 4'd1},
    '{3'd3, 1'b1, 24'h3A2B1C, 3'd0, 8'hFF, 8'hFF, 8'hFF, 16'h0013, 24'h000013, 2'd3, 4'd4},
    '{3'd3, 1'b0, 24'h0000BE, 3'd0, 8'h00, 8'h00, 8'h00, 16'h000B, 24'h00000B, 2'd2, 4'd3},
    '{3'd4, 1'b1, 24'h000000, 3'd0, 8'h00, 8'h00, 8'h00, 16'h0000, 24'h654321, 2'd3, 4'd5},
    '{3'd4, 1'b0, 24'h000000, 3'd0, 8'h00, 8'h00, 8'h00, 16'h0000, 24'h00BEEF, 2'd2, 4'd3},
    '{3'd5, 1'b1, 24'h000000, 3'd0, 8'h00, 8'h00, 8'h00, 16'h0000, 24'h7A1B2C, 2'd3, 4'd5},
    '{3'd5, 1'b0, 24'h000000, 3'd0, 8'h00, 8'h00, 8'h00, 16'h0000, 24'h00C0DE, 2'd2, 4'd3}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, flat = 1'b0, stk_ack = 1'b0;
  logic [2:0] op = '0, opc_hi = '0;
  logic [23:0] pc_in = '0;
  logic [7:0] tgt_x = '0, tgt_h = '0, tgt_l = '0;
  logic [15:0] vec = '0;
  logic [7:0] pop_data, push_data;
  logic push_req, pop_req, busy, pc_we, reti_pulse;
  logic [23:0] pc_next;

  int errors = 0, checks = 0;
  bit done_flag = 0;

  // stack model
  logic [7:0] mem [16];
  logic [3:0] sp = '0;
  logic [7:0] logb [8];
  int nlog = 0;
  logic pre_go = 1'b0, bp = 1'b0;
  logic [3:0] pre_n = '0;
  logic [23:0] pre_val = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  callret_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .flat(flat), .pc_in(pc_in),
    .opc_hi(opc_hi), .tgt_x(tgt_x), .tgt_h(tgt_h), .tgt_l(tgt_l), .vec(vec),
    .stk_ack(stk_ack), .pop_data(pop_data), .push_req(push_req), .pop_req(pop_req),
    .push_data(push_data), .busy(busy), .pc_we(pc_we), .pc_next(pc_next),
    .reti_pulse(reti_pulse)
  );

  assign pop_data = mem[sp];

  always @(posedge clk) begin
    if (pre_go) begin
      sp <= pre_n;
      mem[1] <= pre_val[7:0];
      mem[2] <= pre_val[15:8];
      mem[3] <= pre_val[23:16];
      nlog <= 0;
    end else if (push_req && stk_ack) begin
      mem[sp + 4'd1] <= push_data;
      sp <= sp + 4'd1;
      if (nlog < 8) logb[nlog] <= push_data;
      nlog <= nlog + 1;
    end else if (pop_req && stk_ack) begin
      sp <= sp - 4'd1;
    end
  end

  always @(negedge clk) stk_ack <= bp ? ~stk_ack : 1'b1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic preload(input logic [3:0] n, input logic [23:0] val);
    @(negedge clk);
    pre_n = n; pre_val = val; pre_go = 1'b1;
    @(negedge clk);
    pre_go = 1'b0;
  endtask

  task automatic drive(input vec_t v);
    op = v.op; flat = v.flat; pc_in = v.pc; opc_hi = v.opc;
    tgt_x = v.x; tgt_h = v.h; tgt_l = v.l; vec = v.vec;
  endtask

  // starts an operation and waits for pc_we; lat counts edges from acceptance
  task automatic issue(input vec_t v, output int lat);
    @(negedge clk);
    drive(v); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!pc_we && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  function automatic string req_of(input logic [2:0] o);
    case (o)
      3'd0: return "R4";
      3'd1: return "R5";
      3'd2: return "R11";
      3'd3: return "R6";
      default: return "R3";
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lat;
    vec_t w;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(!busy && !push_req && !pop_req && !pc_we && !reti_pulse, "R1 reset",
        {busy, push_req, pop_req, pc_we, reti_pulse}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      w = VT[i];
      if (w.op >= 3'd4) preload(w.flat ? 4'd3 : 4'd2, w.exp_pc);
      else              preload(4'd0, 24'h0);
      issue(w, lat);
      chk(pc_we && pc_next == w.exp_pc, req_of(w.op), pc_next, w.exp_pc);
      // R7 latency
      chk(lat == int'(w.lat), "R7 latency", lat, w.lat);
      // R8 busy through the pc_we cycle
      chk(busy, "R8 busy at pc_we", busy, 1);
      // R9
      chk(reti_pulse == (w.op == 3'd5), "R9 reti pulse", reti_pulse, (w.op == 3'd5));
      if (w.op <= 3'd1 || w.op == 3'd3) begin
        // R2 push order low, high, ext
        chk(nlog == int'(w.nb), "R2 push count", nlog, w.nb);
        for (int b = 0; b < int'(w.nb); b++)
          chk(logb[b] == w.pc[b*8 +: 8], "R2 push byte", logb[b], w.pc[b*8 +: 8]);
      end else begin
        chk(nlog == 0, "R11 no push", nlog, 0);
      end
      if (w.op >= 3'd4) chk(sp == 4'd0, "R3 pops consumed", sp, 0);
      if (w.op == 3'd2) chk(sp == 4'd0, "R11 no stack move", sp, 0);
      @(negedge clk);
      chk(!busy && !pc_we && !reti_pulse, "R8 idle after", {busy, pc_we, reti_pulse}, 0);
    end

    // R8 backpressure on a flat long call
    bp = 1'b1;
    preload(4'd0, 24'h0);
    issue(VT[0], lat);
    chk(pc_next == 24'hABCDEF, "R8 bp target", pc_next, 24'hABCDEF);
    chk(nlog == 3 && logb[0] == 8'h56 && logb[1] == 8'h34 && logb[2] == 8'h12,
        "R8 bp push order", {logb[0], logb[1], logb[2]}, 24'h563412);
    chk(lat > 4, "R8 bp stretched", lat, 5);
    bp = 1'b0;
    @(negedge clk);

    // R10 start held while busy with a different operation
    preload(4'd0, 24'h0);
    @(negedge clk);
    drive(VT[0]); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    drive(VT[4]);
    lat = 1;
    while (!pc_we && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk(pc_next == 24'hABCDEF, "R10 busy start ignored", pc_next, 24'hABCDEF);
    chk(nlog == 3, "R10 push count", nlog, 3);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);

    // R10 unused op code
    op = 3'd6; start = 1'b1;
    @(negedge clk);
    chk(!busy && !push_req && !pop_req, "R10 op6 rejected", {busy, push_req, pop_req}, 0);
    op = 3'd7;
    @(negedge clk);
    start = 1'b0;
    chk(!busy && !pc_we, "R10 op7 rejected", {busy, pc_we}, 0);

    // R1 reset in the middle of a flat return
    bp = 1'b1;
    preload(4'd3, 24'h111111);
    @(negedge clk);
    drive(VT[8]); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R1 op running", busy, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !push_req && !pop_req && !pc_we && !reti_pulse, "R1 mid reset",
        {busy, push_req, pop_req, pc_we, reti_pulse}, 0);
    rst_n = 1'b1;
    bp = 1'b0;
    @(negedge clk);

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule